// File: doc/BRIEF.md
# Pulse Width Jitter Capture Controller

This block measures how long a periodic pulse from a device under test stays high, in units of an external 1 µs tick enable. The pulse pin is asynchronous and is synchronised inside the block. After a start byte arrives from the host, the block records one width sample for each pulse period into an internal buffer. Once the buffer is full, it streams every sample back to the host as two bytes through a byte-wide transmitter handshake.

A host uses the block in a fixed order. It sends the start byte and lets the device under test toggle its output. It then collects `2 * DEPTH` bytes. The spread of those widths is the jitter of the periodic task that drives the pin.

Top module: `pulse_width_capture`

## Requirements
- R1: After reset, `tx_strobe` and `serial_clr` are low and the block is idle, waiting for a start byte.
- R2: In idle, a `cmd_valid` cycle with `cmd_data` equal to `START_CODE` (default 0x53) starts a capture run and raises `serial_clr` for exactly one cycle. Any other byte is ignored and raises nothing.
- R3: A sample equals the number of clock cycles in which both the synchronised pulse level and `tick_1us` were high, counted from the synchronised rising edge. Cycles with `tick_1us` low add nothing.
- R4: A width whose count would pass 0xFFFF is recorded as 0xFFFF, because the counter saturates instead of wrapping.
- R5: One sample is stored on each synchronised falling edge, at consecutive addresses starting from 0. A pulse that was already high when the run started is not stored.
- R6: After sample number `DEPTH` is stored, acquisition stops and readout begins. Later pulses are not stored.
- R7: Readout sends the samples from address 0 upward, with bits 7:0 of each sample (byte select 0) before bits 15:8 (byte select 1).
- R8: Each byte is presented with a one-cycle `tx_strobe`, and `tx_data` holds that byte. No further strobe occurs until `tx_done` has been seen.
- R9: After the last byte is acknowledged the block returns to idle and accepts a new start. A start byte that arrives during acquisition or readout is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle enable every microsecond |
| pulse_in | input | 1 | Asynchronous pulse from the device under test |
| cmd_valid | input | 1 | A host command byte has been received |
| cmd_data | input | 8 | Received command byte |
| tx_done | input | 1 | Transmitter finished the last byte |
| tx_strobe | output | 1 | Load `tx_data` into the transmitter |
| tx_data | output | 8 | Byte for the transmitter |
| serial_clr | output | 1 | One-cycle reset pulse for the serial interface at run start |

## Verification
A wrong internal state shows up at the ports in one of three ways:
- A miscounting or non-saturating interval counter appears as a wrong byte value, but only when that sample is read out. That can be thousands of cycles after the pulse was measured.
- A write on the wrong edge, a stored partial first pulse, or an address that skips shows up as byte-stream misalignment. It appears on the first strobe after the buffer fills.
- A broken handshake or byte-select fault shows within one or two strobes, as swapped halves or a strobe while an acknowledge is still pending.

The bench therefore compares every streamed byte against widths it chose itself. This includes the saturated width, a zero-tick pulse and a discarded partial pulse.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_SEND = 2'd2,
    ST_WAIT = 2'd3
  } pwc_state_t;

  // saturating step of the interval counter (R3, R4)
  function automatic logic [15:0] width_step(input logic [15:0] cur, input logic en);
    if (!en) return cur;
    if (cur == 16'hFFFF) return cur;
    return cur + 16'd1;
  endfunction

  // byte selector: 0 -> low half, 1 -> high half (R7)
  function automatic logic [7:0] pick_byte(input logic [15:0] word, input logic hi);
    return hi ? word[15:8] : word[7:0];
  endfunction

endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/pwc_width_counter.sv
module pwc_width_counter
  import pwc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rise,
  input  logic        level,
  input  logic        tick,
  output logic [15:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (rise)   count <= width_step(16'd0, tick);
    else             count <= width_step(count, level & tick);
  end
endmodule

// File: rtl/pwc_sample_store.sv
module pwc_sample_store #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             last_slot
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    waddr <= '0;
    else if (clr)  waddr <= '0;
    else if (we)   waddr <= (waddr == LAST) ? '0 : waddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata     = mem[raddr];
  assign last_slot = (waddr == LAST);
endmodule

// File: rtl/pulse_width_capture.sv
module pulse_width_capture
  import pwc_pkg::*;
#(
  parameter int          DEPTH      = 1024,
  parameter logic [7:0]  START_CODE = 8'h53,
  localparam int         AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       pulse_in,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  input  logic       tx_done,
  output logic       tx_strobe,
  output logic [7:0] tx_data,
  output logic       serial_clr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  pwc_state_t  state;
  logic        pulse_level, pulse_rise, pulse_fall;
  logic [15:0] width_q, rd_word;
  logic        start_evt, armed, mem_we, wr_last, full_evt;
  logic [AW-1:0] rd_addr;
  logic        hi_sel;
  logic        in_readout;

  pwc_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pulse_in),
    .level(pulse_level), .rise(pulse_rise), .fall(pulse_fall)
  );

  pwc_width_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .rise(pulse_rise),
    .level(pulse_level), .tick(tick_1us), .count(width_q)
  );

  pwc_sample_store #(.DEPTH(DEPTH), .WIDTH(16)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .we(mem_we),
    .wdata(width_q), .raddr(rd_addr), .rdata(rd_word), .last_slot(wr_last)
  );

  assign start_evt  = (state == ST_IDLE) && cmd_valid && (cmd_data == START_CODE);
  assign mem_we     = (state == ST_ACQ) && pulse_fall && armed;
  assign full_evt   = mem_we && wr_last;
  assign in_readout = (state == ST_SEND) || (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      rd_addr    <= '0;
      hi_sel     <= 1'b0;
      serial_clr <= 1'b0;
    end else begin
      serial_clr <= start_evt;
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state <= ST_ACQ;
            armed <= 1'b0;
          end
        end
        ST_ACQ: begin
          if (pulse_rise) armed <= 1'b1;
          if (full_evt) begin
            state   <= ST_SEND;
            rd_addr <= '0;
            hi_sel  <= 1'b0;
          end
        end
        ST_SEND: state <= ST_WAIT;
        ST_WAIT: begin
          if (tx_done) begin
            if (!hi_sel) begin
              hi_sel <= 1'b1;
              state  <= ST_SEND;
            end else begin
              hi_sel <= 1'b0;
              if (rd_addr == LAST) begin
                state <= ST_IDLE;
              end else begin
                rd_addr <= rd_addr + 1'b1;
                state   <= ST_SEND;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_strobe = (state == ST_SEND);
  assign tx_data   = pick_byte(rd_word, hi_sel);
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_strobe,
  input logic        tx_done,
  input logic        serial_clr,
  input logic        start_evt,
  input logic        mem_we,
  input logic        pulse_rise,
  input logic        pulse_fall,
  input logic        pulse_level,
  input logic        in_readout,
  input logic [15:0] width_q
);
  logic ack_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ack_pending <= 1'b0;
    else if (tx_strobe)  ack_pending <= 1'b1;
    else if (tx_done)    ack_pending <= 1'b0;
  end

  assert_clr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serial_clr |=> !serial_clr);

  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_level && !pulse_rise && !start_evt) |=> $stable(width_q));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q == 16'hFFFF && !pulse_rise && !start_evt) |=> (width_q == 16'hFFFF));

  assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> pulse_fall);

  assert_no_write_readout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_readout);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  assert_wait_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> !ack_pending);
endmodule

bind pulse_width_capture pwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_strobe(tx_strobe), .tx_done(tx_done),
  .serial_clr(serial_clr), .start_evt(start_evt), .mem_we(mem_we),
  .pulse_rise(pulse_rise), .pulse_fall(pulse_fall), .pulse_level(pulse_level),
  .in_readout(in_readout), .width_q(width_q)
);

// File: tb/tb_pulse_width_capture.sv
`timescale 1ns/1ps
module tb_pulse_width_capture;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1us = 1'b1;
  logic       pulse_in = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       tx_done = 1'b0;
  logic       tx_strobe;
  logic [7:0] tx_data;
  logic       serial_clr;

  int checks = 0;
  int errors = 0;
  int rx_bytes = 0;
  int clr_seen = 0;
  int hs_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pulse_width_capture #(.DEPTH(DEPTH), .START_CODE(8'h53)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .pulse_in(pulse_in),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .tx_done(tx_done),
    .tx_strobe(tx_strobe), .tx_data(tx_data), .serial_clr(serial_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: low byte first, then high (R7)
  task automatic push_width(input int w);
    int v = (w > 65535) ? 65535 : w;
    exp_q.push_back(8'(v & 8'hFF));
    exp_q.push_back(8'((v >> 8) & 8'hFF));
  endtask

  task automatic drive_pulse(input int high, input int low);
    pulse_in = 1'b1;
    repeat (high) @(negedge clk);
    pulse_in = 1'b0;
    repeat (low) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares strobed bytes and answers with tx_done
  always @(negedge clk) begin
    tx_done = 1'b0;
    if (serial_clr) clr_seen++;
    if (hs_cnt > 0) begin
      hs_cnt--;
      if (hs_cnt == 0) tx_done = 1'b1;
    end
    if (rst_n && tx_strobe) begin
      check(hs_cnt == 0, "R8 strobe while ack pending", hs_cnt, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected byte", int'(tx_data), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_data == e, "R7 byte stream", int'(tx_data), int'(e));
      end
      rx_bytes++;
      hs_cnt = 3;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_strobe == 1'b0, "R1 strobe low after reset", tx_strobe, 0);
    check(serial_clr == 1'b0, "R1 clr low after reset", serial_clr, 0);

    // R2: a non-start byte is ignored
    send_cmd(8'h41);
    drive_pulse(4, 6);
    repeat (5) @(negedge clk);
    check(clr_seen == 0, "R2 other byte ignored", clr_seen, 0);
    check(rx_bytes == 0, "R2 no activity on other byte", rx_bytes, 0);

    // R5: pulse already high at start is discarded
    pulse_in = 1'b1;
    repeat (4) @(negedge clk);
    send_cmd(8'h53);
    repeat (3) @(negedge clk);
    pulse_in = 1'b0;
    repeat (6) @(negedge clk);
    check(clr_seen == 1, "R2 start pulses serial_clr once", clr_seen, 1);

    push_width(7);   drive_pulse(7, 6);     // R3
    push_width(1);   drive_pulse(1, 6);     // R3 shortest pulse
    push_width(300); drive_pulse(300, 6);   // R3 high byte non-zero
    // R3: tick held low across a whole pulse gives zero
    tick_1us = 1'b0;
    repeat (3) @(negedge clk);
    push_width(0);   drive_pulse(10, 6);
    tick_1us = 1'b1;
    push_width(12);  drive_pulse(12, 4);
    send_cmd(8'h53);                        // R9 start ignored mid-run
    push_width(70000); drive_pulse(70000, 6); // R4 saturation
    push_width(3);   drive_pulse(3, 6);
    push_width(9);   drive_pulse(9, 6);     // fills buffer (R6)
    drive_pulse(15, 6);                     // R6 not stored
    send_cmd(8'h53);                        // R9 ignored during readout

    wait (rx_bytes == 2 * DEPTH);
    repeat (10) @(negedge clk);
    check(rx_bytes == 2 * DEPTH, "R6 byte count run 1", rx_bytes, 2 * DEPTH);
    check(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);
    check(clr_seen == 1, "R9 start ignored while busy", clr_seen, 1);

    // R9: second run after returning to idle
    send_cmd(8'h53);
    repeat (4) @(negedge clk);
    check(clr_seen == 2, "R9 new start accepted", clr_seen, 2);
    for (int i = 0; i < DEPTH; i++) begin
      push_width(20 + 37 * i);
      drive_pulse(20 + 37 * i, 5 + i);
    end
    wait (rx_bytes == 4 * DEPTH);
    repeat (10) @(negedge clk);
    check(rx_bytes == 4 * DEPTH, "R6 byte count run 2", rx_bytes, 4 * DEPTH);
    check(exp_q.size() == 0, "R7 run 2 drained", exp_q.size(), 0);
    check(tx_strobe == 1'b0, "R9 idle after readout", tx_strobe, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule